// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers interrupt pulses from peripherals and presents one chosen request to the processor. A request can go out as a fast interrupt (`fiq`) or as a normal interrupt (`irq`). Most sources latch directly into a main pending register. One main source is a group: its own pulses land in a sub-pending register, and any sub-pending bit whose sub-mask is clear keeps the group's main pending bit set.

A mode register routes at most one source to the fast line, and that path ignores the main mask. All other unmasked pending sources go to an arbiter. The arbiter is a two-state machine. In `ARB_IDLE` it searches for a winner. The `GRANT` transition latches a one-hot active register and its binary index and moves to `ARB_HELD`. The `RELEASE` transition returns to `ARB_IDLE` when software clears the active bit. Search order is fixed, with the lowest index first. An optional rotate control starts the search just after the source served last.

Software reaches every register through a plain bus. The bus has an address, a write strobe, write data and combinational read data. The pending registers are write-1-to-clear. The correct order for clearing a group source is: the sub-pending bit, then the main pending bit, then the active bit.

Top module: `irq_ctrl_top`

## Requirements
- R1: On reset, the pending, sub-pending, mode, control, active and index registers hold 0, both main and sub masks hold all ones, and `irq` and `fiq` are low.
- R2: A pulse on `src_pulse[i]` (i not the group index) sets main pending bit i at the next clock edge. Writing a 1 to bit i of address 0 clears it. If a pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: A pulse on `sub_pulse[j]` sets sub-pending bit j even while sub-mask bit j is 1. Main pending bit GRP_IDX (default 2) is set on the edge after a sub-pending bit with a clear sub-mask bit is seen. `src_pulse[GRP_IDX]` has no effect.
- R4: A main source whose bit in the mask register (address 1) is 1 is never granted. It stays pending and can be granted after it is unmasked.
- R5: A write to the mode register (address 2) takes effect only if the data has at most one bit set. Otherwise the register keeps its old value.
- R6: `fiq` is high exactly while the main pending bit selected by the mode register is set, whatever the mask. That source is never granted on `irq`.
- R7: In `ARB_IDLE`, when an unmasked, non-fast source is pending, the next edge performs `GRANT`. It sets exactly one active bit (address 4) and writes that bit's index to the index register (address 5). With rotation off, the lowest eligible index wins. `irq` is high while the active register is non-zero.
- R8: In `ARB_HELD`, the active register holds its value. Writes to address 4 that miss the set bit are ignored. Writing a 1 to the set bit performs `RELEASE` at that edge, and a new `GRANT` can occur on the next edge.
- R9: When bit 0 of the control register (address 3) is 1, the search starts at one past the last granted index and wraps around. After reset, the last granted index counts as N_SRC-1.
- R10: Read data shows the register at `bus_addr`. Addresses 0 to 7 map to: pending, mask, mode, control, active, index, sub-pending, sub-mask. Narrower fields are zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | N_SRC (8) | One-cycle event per main source |
| sub_pulse | input | N_SUB (4) | One-cycle event per grouped sub-source |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | N_SRC (8) | Write data |
| bus_rdata | output | N_SRC (8) | Read data for `bus_addr` |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Two pairs of events can collide in a single cycle. In the first, a new peripheral pulse meets a write-1-to-clear on the same pending bit. In the second, a `RELEASE` write meets further pending sources waiting for the next `GRANT`. The bench provokes the first by driving a pulse together with a clear of the same bit; the bit must survive. It provokes the second by clearing the active bit while other sources are pending and checking the next winner one edge later. A behavioural model in the bench tracks every register, and each cycle its prediction is compared against `irq`, `fiq` and the read data.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [2:0] {
        REG_SRCPEND = 3'd0,
        REG_MASK    = 3'd1,
        REG_MODE    = 3'd2,
        REG_CTRL    = 3'd3,
        REG_ACTIVE  = 3'd4,
        REG_INDEX   = 3'd5,
        REG_SUBPEND = 3'd6,
        REG_SUBMASK = 3'd7
    } reg_addr_e;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

endpackage

// File: rtl/irq_ctrl_pend.sv
module irq_ctrl_pend #(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned N_SUB   = 4,
    parameter int unsigned GRP_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic [N_SUB-1:0] sub_pulse,
    input  logic [N_SRC-1:0] src_clr,
    input  logic [N_SUB-1:0] sub_clr,
    input  logic [N_SUB-1:0] sub_mask,
    output logic [N_SRC-1:0] src_pend,
    output logic [N_SUB-1:0] sub_pend
);

    logic             group_req;
    logic [N_SRC-1:0] set_vec;
    logic             grp_pulse_unused;

    assign group_req        = |(sub_pend & ~sub_mask);
    assign grp_pulse_unused = src_pulse[GRP_IDX];

    // The group bit takes its set term from the sub-sources; every other
    // bit takes it from its own pulse input.
    for (genvar i = 0; i < N_SRC; i++) begin : g_set
        if (i == GRP_IDX) begin : g_grp
            assign set_vec[i] = group_req;
        end else begin : g_direct
            assign set_vec[i] = src_pulse[i];
        end
    end

    // A set in the same cycle as a clear wins, so no event is lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_pend <= '0;
            sub_pend <= '0;
        end else begin
            src_pend <= (src_pend & ~src_clr) | set_vec;
            sub_pend <= (sub_pend & ~sub_clr) | sub_pulse;
        end
    end

endmodule

// File: rtl/irq_ctrl_arb.sv
module irq_ctrl_arb
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    parameter int unsigned IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] eligible,
    input  logic             rot_en,
    input  logic [N_SRC-1:0] act_clr,
    output logic [N_SRC-1:0] act_pend,
    output logic [IDX_W-1:0] act_idx,
    output logic             irq_o
);

    localparam logic [N_SRC-1:0] ONE_HOT0 = N_SRC'(1);

    arb_state_e       state_q;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] win;
    logic             found;
    int               base;

    // Circular search: start at index 0, or one past the last grant when
    // rotation is enabled.
    always_comb begin
        found = 1'b0;
        win   = '0;
        base  = (rot_en && int'(last_q) != N_SRC - 1) ? int'(last_q) + 1 : 0;
        for (int i = 0; i < N_SRC; i++) begin
            int k;
            k = base + i;
            if (k >= N_SRC) begin
                k = k - N_SRC;
            end
            if (!found && eligible[k]) begin
                found = 1'b1;
                win   = IDX_W'(k);
            end
        end
    end

    // State register: GRANT (IDLE -> HELD) and RELEASE (HELD -> IDLE).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ARB_IDLE;
            act_pend <= '0;
            act_idx  <= '0;
            last_q   <= IDX_W'(N_SRC - 1);
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (found) begin
                        state_q  <= ARB_HELD;
                        act_pend <= ONE_HOT0 << win;
                        act_idx  <= win;
                        last_q   <= win;
                    end
                end
                ARB_HELD: begin
                    if ((act_clr & act_pend) != '0) begin
                        state_q  <= ARB_IDLE;
                        act_pend <= '0;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    // Output process.
    always_comb begin
        irq_o = (state_q == ARB_HELD);
    end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned N_SUB   = 4,
    parameter int unsigned GRP_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic [N_SUB-1:0] sub_pulse,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [N_SRC-1:0] bus_wdata,
    output logic [N_SRC-1:0] bus_rdata,
    output logic             irq,
    output logic             fiq
);

    localparam int unsigned DATA_W = N_SRC;
    localparam int unsigned IDX_W  = $clog2(N_SRC);

    reg_addr_e        addr;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] mode_q;
    logic             rot_q;
    logic [N_SUB-1:0] sub_mask_q;
    logic [N_SRC-1:0] src_pend;
    logic [N_SUB-1:0] sub_pend;
    logic [N_SRC-1:0] act_pend;
    logic [IDX_W-1:0] act_idx;
    logic [N_SRC-1:0] src_clr;
    logic [N_SUB-1:0] sub_clr;
    logic [N_SRC-1:0] act_clr;
    logic [N_SRC-1:0] eligible;
    logic             mode_ok;

    assign addr     = reg_addr_e'(bus_addr);
    assign src_clr  = (bus_wr && addr == REG_SRCPEND) ? bus_wdata : '0;
    assign act_clr  = (bus_wr && addr == REG_ACTIVE)  ? bus_wdata : '0;
    assign sub_clr  = (bus_wr && addr == REG_SUBPEND) ? bus_wdata[N_SUB-1:0] : '0;
    assign mode_ok  = (bus_wdata & (bus_wdata - N_SRC'(1))) == '0;
    assign eligible = src_pend & ~mask_q & ~mode_q;
    assign fiq      = |(src_pend & mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '1;
            mode_q     <= '0;
            rot_q      <= 1'b0;
            sub_mask_q <= '1;
        end else if (bus_wr) begin
            if (addr == REG_MASK)              mask_q     <= bus_wdata;
            if (addr == REG_MODE && mode_ok)   mode_q     <= bus_wdata;
            if (addr == REG_CTRL)              rot_q      <= bus_wdata[0];
            if (addr == REG_SUBMASK)           sub_mask_q <= bus_wdata[N_SUB-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            REG_SRCPEND: bus_rdata = src_pend;
            REG_MASK:    bus_rdata = mask_q;
            REG_MODE:    bus_rdata = mode_q;
            REG_CTRL:    bus_rdata = DATA_W'(rot_q);
            REG_ACTIVE:  bus_rdata = act_pend;
            REG_INDEX:   bus_rdata = DATA_W'(act_idx);
            REG_SUBPEND: bus_rdata = DATA_W'(sub_pend);
            REG_SUBMASK: bus_rdata = DATA_W'(sub_mask_q);
            default:     bus_rdata = '0;
        endcase
    end

    irq_ctrl_pend #(
        .N_SRC   (N_SRC),
        .N_SUB   (N_SUB),
        .GRP_IDX (GRP_IDX)
    ) pend_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .sub_pulse (sub_pulse),
        .src_clr   (src_clr),
        .sub_clr   (sub_clr),
        .sub_mask  (sub_mask_q),
        .src_pend  (src_pend),
        .sub_pend  (sub_pend)
    );

    irq_ctrl_arb #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) arb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .eligible (eligible),
        .rot_en   (rot_q),
        .act_clr  (act_clr),
        .act_pend (act_pend),
        .act_idx  (act_idx),
        .irq_o    (irq)
    );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int unsigned N_SRC   = 8,
    parameter int unsigned N_SUB   = 4,
    parameter int unsigned GRP_IDX = 2,
    parameter int unsigned IDX_W   = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_pend,
    input logic [N_SUB-1:0] sub_pend,
    input logic [N_SUB-1:0] sub_mask_q,
    input logic [N_SRC-1:0] mask_q,
    input logic [N_SRC-1:0] mode_q,
    input logic [N_SRC-1:0] act_pend,
    input logic [IDX_W-1:0] act_idx,
    input logic [N_SRC-1:0] act_clr
);

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_pend)); // R7

    AST_INDEX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pend != '0) |-> act_pend[act_idx]); // R7

    AST_MODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_q)); // R5

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pend != '0 && $past(act_pend) == '0)
        |-> ((act_pend & $past(src_pend & ~mask_q & ~mode_q)) != '0)); // R4

    AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pend != '0 && (act_clr & act_pend) == '0)
        |=> (act_pend == $past(act_pend))); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_clr & act_pend) != '0) |=> (act_pend == '0)); // R8

    AST_GROUP_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        ((sub_pend & ~sub_mask_q) != '0) |=> src_pend[GRP_IDX]); // R3

endmodule

bind irq_ctrl_top irq_ctrl_chk #(
    .N_SRC   (N_SRC),
    .N_SUB   (N_SUB),
    .GRP_IDX (GRP_IDX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pend   (src_pend),
    .sub_pend   (sub_pend),
    .sub_mask_q (sub_mask_q),
    .mask_q     (mask_q),
    .mode_q     (mode_q),
    .act_pend   (act_pend),
    .act_idx    (act_idx),
    .act_clr    (act_clr)
);

// File: tb/irq_ctrl_top_tb_top.sv
module irq_ctrl_top_tb_top;

    localparam int GRP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_pulse = '0;
    logic [3:0] sub_pulse = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       fiq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    irq_ctrl_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .sub_pulse (sub_pulse),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .fiq       (fiq)
    );

    // Behavioural reference model.
    logic [7:0] m_src, m_mask, m_mode, m_ip, c_src, c_ip, elig, setv;
    logic [3:0] m_sub, m_submask, c_sub;
    logic       m_rot, m_held, got;
    int         m_off, m_last, base, k;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_sub = 0; m_mask = 8'hFF; m_submask = 4'hF;
            m_mode = 0; m_rot = 0; m_ip = 0; m_off = 0; m_last = 7; m_held = 0;
        end else begin
            c_src = (bus_wr && bus_addr == 3'd0) ? bus_wdata : 8'h00;
            c_ip  = (bus_wr && bus_addr == 3'd4) ? bus_wdata : 8'h00;
            c_sub = (bus_wr && bus_addr == 3'd6) ? bus_wdata[3:0] : 4'h0;
            if (m_held) begin
                if ((c_ip & m_ip) != 0) begin m_ip = 0; m_held = 0; end
            end else begin
                elig = m_src & ~m_mask & ~m_mode;
                base = m_rot ? (m_last + 1) % 8 : 0;
                got  = 0;
                for (int i = 0; i < 8; i++) begin
                    k = (base + i) % 8;
                    if (!got && elig[k]) begin
                        got = 1; m_ip = 8'h01 << k; m_off = k; m_last = k; m_held = 1;
                    end
                end
            end
            setv = src_pulse;
            setv[GRP] = |(m_sub & ~m_submask);
            m_src = (m_src & ~c_src) | setv;
            m_sub = (m_sub & ~c_sub) | sub_pulse;
            if (bus_wr) begin
                case (bus_addr)
                    3'd1: m_mask = bus_wdata;
                    3'd2: if ($countones(bus_wdata) <= 1) m_mode = bus_wdata;
                    3'd3: m_rot = bus_wdata[0];
                    3'd7: m_submask = bus_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_src;
            3'd1: return m_mask;
            3'd2: return m_mode;
            3'd3: return {7'b0, m_rot};
            3'd4: return m_ip;
            3'd5: return 8'(m_off);
            3'd6: return {4'b0, m_sub};
            default: return {4'b0, m_submask};
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == (m_ip != 0), "R7 R8 irq vs model", 8'(irq), 8'(m_ip != 0));
            chk(fiq == |(m_src & m_mode), "R6 fiq vs model", 8'(fiq), 8'(|(m_src & m_mode)));
            chk(bus_rdata == model_read(bus_addr), "R10 rdata vs model", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic cyc(input logic [2:0] a, input bit w, input logic [7:0] d,
                       input logic [7:0] s, input logic [3:0] u);
        @(negedge clk); #1;
        bus_addr = a; bus_wr = w; bus_wdata = d; src_pulse = s; sub_pulse = u;
        @(negedge clk); #1;
        bus_wr = 0; src_pulse = 0; sub_pulse = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(a, 1'b1, d, 8'h00, 4'h0);
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        bus_addr = a; bus_wr = 0;
        #2 chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #3;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 8'h00, "R1 pending"); rd(3'd1, 8'hFF, "R1 mask");
        rd(3'd2, 8'h00, "R1 mode");    rd(3'd3, 8'h00, "R1 ctrl");
        rd(3'd4, 8'h00, "R1 active");  rd(3'd5, 8'h00, "R1 index");
        rd(3'd6, 8'h00, "R1 subpend"); rd(3'd7, 8'h0F, "R1 submask");
        chk(!irq && !fiq, "R1 outputs low", {6'b0, irq, fiq}, 8'h00);

        // R7 fixed priority, R2 set
        wr(3'd1, 8'h00);
        cyc(3'd0, 0, 8'h00, 8'h22, 4'h0);
        rd(3'd0, 8'h22, "R2 pending set");
        rd(3'd5, 8'h01, "R7 lowest index wins");
        rd(3'd4, 8'h02, "R7 active one-hot");
        chk(irq, "R7 irq high", 8'(irq), 8'h01);
        // R8 hold and release
        wr(3'd0, 8'h02);
        wr(3'd4, 8'h20);
        rd(3'd4, 8'h02, "R8 wrong-bit clear ignored");
        wr(3'd4, 8'h02);
        rd(3'd5, 8'h05, "R8 next grant after release");
        rd(3'd4, 8'h20, "R8 next active");
        wr(3'd0, 8'h20); wr(3'd4, 8'h20);
        idle(2);
        chk(!irq, "R8 irq low after release", 8'(irq), 8'h00);

        // R2 collision: pulse and clear same bit
        cyc(3'd0, 0, 8'h00, 8'h40, 4'h0);
        cyc(3'd0, 1, 8'h40, 8'h40, 4'h0);
        rd(3'd0, 8'h40, "R2 set wins over clear");
        wr(3'd0, 8'h40); wr(3'd4, 8'h40);

        // R4 mask
        wr(3'd1, 8'h10);
        cyc(3'd0, 0, 8'h00, 8'h10, 4'h0);
        idle(2);
        chk(!irq, "R4 masked source not granted", 8'(irq), 8'h00);
        rd(3'd0, 8'h10, "R4 masked source still pending");
        wr(3'd1, 8'h00);
        idle(2);
        rd(3'd5, 8'h04, "R4 granted after unmask");
        wr(3'd0, 8'h10); wr(3'd4, 8'h10);

        // R3 group
        cyc(3'd0, 0, 8'h00, 8'h00, 4'h1);
        idle(2);
        rd(3'd6, 8'h01, "R3 sub-pending set while masked");
        rd(3'd0, 8'h00, "R3 masked sub does not feed main");
        cyc(3'd0, 0, 8'h00, 8'h04, 4'h0);
        idle(2);
        rd(3'd0, 8'h00, "R3 direct pulse on group bit ignored");
        wr(3'd7, 8'h0E);
        idle(2);
        rd(3'd5, 8'h02, "R3 group source granted");
        wr(3'd6, 8'h01); wr(3'd0, 8'h04); wr(3'd4, 8'h04);
        idle(2);
        rd(3'd0, 8'h00, "R3 clear order empties group");

        // R5 mode, R6 fast path
        wr(3'd2, 8'h03);
        rd(3'd2, 8'h00, "R5 multi-bit mode write ignored");
        wr(3'd2, 8'h80);
        rd(3'd2, 8'h80, "R5 single-bit mode accepted");
        wr(3'd1, 8'hFF);
        cyc(3'd0, 0, 8'h00, 8'h80, 4'h0);
        idle(1);
        chk(fiq, "R6 fiq despite mask", 8'(fiq), 8'h01);
        wr(3'd1, 8'h7F);
        idle(2);
        chk(!irq, "R6 fast source not on irq", 8'(irq), 8'h00);
        wr(3'd0, 8'h80);
        idle(1);
        chk(!fiq, "R6 fiq low after clear", 8'(fiq), 8'h00);
        wr(3'd2, 8'h00); wr(3'd1, 8'h00);

        // R9 rotation: last granted was 2
        wr(3'd3, 8'h01);
        cyc(3'd0, 0, 8'h00, 8'h0B, 4'h0);
        idle(2);
        rd(3'd5, 8'h03, "R9 search starts after last");
        wr(3'd0, 8'h08); wr(3'd4, 8'h08);
        idle(2);
        rd(3'd5, 8'h00, "R9 search wraps to zero");
        wr(3'd0, 8'h01); wr(3'd4, 8'h01);
        idle(2);
        rd(3'd5, 8'h01, "R9 next after zero");
        wr(3'd0, 8'h02); wr(3'd4, 8'h02);
        idle(3);
        finish_run();
    end

endmodule